// File: doc/BRIEF.md
# Periodic Tick and Interrupt Status Unit

This unit sits beside a timekeeping core and turns its raw timing pulses into software-visible events. A single-cycle reference tick at 1024 Hz drives a binary divider. The divider produces nine periodic events, spaced by factors of two from 512 Hz down to 2 Hz. Two further pulses come from the timekeeper: the once-per-second tick and the alarm match. Each event sets its own bit in a 16-bit status register.

A 16-bit enable register selects which pending bits reach the interrupt line. The line is high while any status bit and its enable bit are both set. Software clears pending bits by writing ones to the status register; a write of all ones empties it. Software silences the line by writing zero to the enable register. Status bits latch whether or not they are enabled, so a pending alarm can be found by polling.

Top module: `periodic_irq_unit`

## Requirements
- R1: After reset the status register and the enable register read zero, and `irq_o` is low.
- R2: An alarm pulse sets status bit 2 and a 1 Hz pulse sets status bit 4. Both bits set whatever the enable register holds.
- R3: The divider counts reference ticks from reset. Status bit 15 sets on every 2nd tick, bit 14 on every 4th, and so on down to bit 8 on every 256th. Bit 7 sets on every 512th tick. Each rate sets its bit first on tick number 2, 4, ... 512.
- R4: A write to the status register (address 0x14) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: An event arriving in the same cycle as a clear of its own bit wins, and the bit stays set.
- R6: `irq_o` is high exactly when some status bit and the matching enable bit are both set.
- R7: Bits 0, 1, 3, 5 and 6 of both registers always read zero, and writes to them are ignored. Bit 0 is held for a stopwatch event that this unit does not produce.
- R8: Writing 0xFFFF to the status register clears every bit. Writing 0 to the enable register drives `irq_o` low in the next cycle.
- R9: With no event and no write, the status register holds its value.
- R10: A write to the enable register (address 0x18) loads it. A write to any other address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_tick_i | input | 1 | Single-cycle 1024 Hz reference tick |
| sec_tick_i | input | 1 | Single-cycle 1 Hz tick |
| alarm_i | input | 1 | Single-cycle alarm match pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Write address (0x14 status, 0x18 enable) |
| wdata_i | input | 16 | Write data |
| status_o | output | 16 | Status register contents |
| enable_o | output | 16 | Enable register contents |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The assertions assume three things about the inputs. The reference, second and alarm inputs are single-cycle pulses synchronous to `clk_i`. A write strobe lasts one cycle. Reset is released away from any pulse.

The stimulus drives every pulse and strobe for exactly one cycle. It changes inputs only just after a falling edge. It keeps the reference tick idle while register behaviour is being checked, so the divider does not move. Because of that, the tick count seen by the divider test starts from a known zero.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 8;
  localparam int NUM_RATES  = 9;
  localparam int ALARM_BIT  = 2;
  localparam int SEC_BIT    = 4;
  localparam int LADDER_TOP = 15;  // fastest rate, ladder descends from here
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 8'h14;
  localparam logic [ADDR_W-1:0] ENABLE_ADDR = 8'h18;

  function automatic logic [DATA_W-1:0] impl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[ALARM_BIT] = 1'b1;
    m[SEC_BIT]   = 1'b1;
    for (int i = 0; i < NUM_RATES; i++) m[LADDER_TOP-i] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] IMPL_MASK = impl_mask();
endpackage

// File: rtl/tick_ladder.sv
module tick_ladder #(
  parameter int NUM_RATES = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ref_tick_i,
  output logic [NUM_RATES-1:0] rate_pulse_o
);
  logic [NUM_RATES-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (ref_tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // rate i has period 2^(i+1) ticks: fires when the low i+1 bits are about to wrap
  for (genvar i = 0; i < NUM_RATES; i++) begin : g_rate
    assign rate_pulse_o[i] = ref_tick_i & (&cnt_q[i:0]);
    if (i > 0) begin : g_nest
      assert_nested_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rate_pulse_o[i] |-> rate_pulse_o[i-1]);
    end
  end

  assert_pulse_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rate_pulse_o) |-> ref_tick_i);
endmodule

// File: rtl/w1c_status_reg.sv
module w1c_status_reg #(
  parameter int                DATA_W = 16,
  parameter logic [DATA_W-1:0] MASK   = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] ev_i,
  input  logic              clr_en_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] status_o
);
  logic [DATA_W-1:0] status_q, clr_bits, status_d;

  assign clr_bits = clr_en_i ? clr_i : '0;
  // set has priority over clear
  assign status_d = ((status_q & ~clr_bits) | ev_i) & MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign status_o = status_q;

  assert_event_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ev_i & MASK) != '0) |=> ((status_q & $past(ev_i & MASK)) == $past(ev_i & MASK)));

  assert_w1c_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((status_q & $past(clr_i & ~ev_i)) == '0));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_en_i && ev_i == '0) |=> $stable(status_q));

  assert_rsvd_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & ~MASK) == '0);
endmodule

// File: rtl/periodic_irq_unit.sv
module periodic_irq_unit
  import tick_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              sec_tick_i,
  input  logic              alarm_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] enable_o,
  output logic              irq_o
);
  logic [NUM_RATES-1:0] rate_pulse;
  logic [DATA_W-1:0]    ev;
  logic [DATA_W-1:0]    enable_q;
  logic                 wr_status, wr_enable;

  assign wr_status = wr_en_i && (addr_i == STATUS_ADDR);
  assign wr_enable = wr_en_i && (addr_i == ENABLE_ADDR);

  tick_ladder #(.NUM_RATES(NUM_RATES)) u_ladder (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ref_tick_i   (ref_tick_i),
    .rate_pulse_o (rate_pulse)
  );

  always_comb begin
    ev = '0;
    ev[ALARM_BIT] = alarm_i;
    ev[SEC_BIT]   = sec_tick_i;
    for (int i = 0; i < NUM_RATES; i++) ev[LADDER_TOP-i] = rate_pulse[i];
  end

  w1c_status_reg #(.DATA_W(DATA_W), .MASK(IMPL_MASK)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .clr_en_i (wr_status),
    .clr_i    (wdata_i),
    .status_o (status_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        enable_q <= '0;
    else if (wr_enable) enable_q <= wdata_i & IMPL_MASK;
  end

  assign enable_o = enable_q;
  assign irq_o    = |(status_o & enable_q);

  assert_irq_silenced_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_enable && wdata_i == '0) |=> !irq_o);

  assert_irq_needs_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (enable_o != '0 && status_o != '0));

  assert_other_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i != ENABLE_ADDR) |=> $stable(enable_q));
endmodule

// File: tb/periodic_irq_unit_tb.sv
`timescale 1ns/100ps
module periodic_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0, sec_tick = 1'b0, alarm = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] status, enable;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  periodic_irq_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .sec_tick_i(sec_tick),
    .alarm_i(alarm), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .status_o(status), .enable_o(enable), .irq_o(irq)
  );

  typedef struct packed {
    logic [1:0]  op;      // 0 idle, 1 write, 2 alarm pulse, 3 second pulse
    logic [7:0]  addr;
    logic [15:0] data;
    logic [15:0] exp_st;
    logic [15:0] exp_en;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 8'h00, 16'h0000, 16'h0004, 16'h0000, 1'b0}, // R2 alarm latches, disabled
    '{2'd3, 8'h00, 16'h0000, 16'h0014, 16'h0000, 1'b0}, // R2 second tick
    '{2'd1, 8'h18, 16'hFFFF, 16'h0014, 16'hFF94, 1'b1}, // R7 R6
    '{2'd1, 8'h14, 16'h0004, 16'h0010, 16'hFF94, 1'b1}, // R4 clear alarm only
    '{2'd1, 8'h18, 16'h0004, 16'h0010, 16'h0004, 1'b0}, // R6 masked out
    '{2'd2, 8'h00, 16'h0000, 16'h0014, 16'h0004, 1'b1}, // R6 enabled bit pending
    '{2'd1, 8'h1C, 16'hFFFF, 16'h0014, 16'h0004, 1'b1}, // R10 other address
    '{2'd1, 8'h14, 16'h0000, 16'h0014, 16'h0004, 1'b1}, // R4 zeros leave bits
    '{2'd1, 8'h18, 16'h0000, 16'h0014, 16'h0000, 1'b0}, // R8 silence line
    '{2'd1, 8'h14, 16'hFFFF, 16'h0000, 16'h0000, 1'b0}, // R8 clear all
    '{2'd0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0}  // R9 idle hold
  };

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    ref_tick = 1'b0; sec_tick = 1'b0; alarm = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    cyc();
  endtask

  function automatic logic [15:0] ladder_exp(int n);
    logic [15:0] e = '0;
    for (int i = 0; i < 9; i++) if (n % (2 << i) == 0) e[15-i] = 1'b1;
    return e;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", status, 16'h0000);
    chk("R1 enable", enable, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);

    for (int v = 0; v < NV; v++) begin
      case (VECS[v].op)
        2'd1: begin wr_en = 1'b1; addr = VECS[v].addr; wdata = VECS[v].data; end
        2'd2: alarm = 1'b1;
        2'd3: sec_tick = 1'b1;
        default: ;
      endcase
      cyc();
      chk($sformatf("R2/R4/R6/R8/R10 vec%0d status", v), status, VECS[v].exp_st);
      chk($sformatf("R7/R10 vec%0d enable", v), enable, VECS[v].exp_en);
      chk($sformatf("R6 vec%0d irq", v), {15'b0, irq}, {15'b0, VECS[v].exp_irq});
    end

    // R7: reserved status bits cannot be set through writes
    wr(8'h14, 16'h006B);
    chk("R7 reserved status", status, 16'h0000);

    // R5: event beats simultaneous clear; other cleared bit goes
    sec_tick = 1'b1; cyc();
    alarm = 1'b1; wr_en = 1'b1; addr = 8'h14; wdata = 16'h0014;
    cyc();
    chk("R5 event wins", status, 16'h0004);
    wr(8'h14, 16'hFFFF);
    chk("R8 clear all", status, 16'h0000);

    // R3: divider ladder from a fresh count
    for (int n = 1; n <= 512; n++) begin
      ref_tick = 1'b1;
      cyc();
      chk($sformatf("R3 tick %0d", n), status, ladder_exp(n));
      wr(8'h14, 16'hFFFF);
    end

    // R1: reset mid-run
    wr(8'h18, 16'hFFFF);
    alarm = 1'b1; cyc();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 re-reset status", status, 16'h0000);
    chk("R1 re-reset enable", enable, 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule